// File: doc/BRIEF.md
# Auxiliary-Channel Reply Status Decoder

This block turns a captured auxiliary-channel reply into a transaction outcome. The receiver in front of it writes the reply bytes into a small buffer, then pulses a capture-complete strobe. With that strobe come the received byte count and a set of line-error flags. From these the block produces three things: an outcome (success, timeout or invalid reply), a decoded reply code taken from the first byte, and the number of payload bytes, which excludes that status byte.

The host arms a wait window when it launches a request. If no capture completes within the window, the block reports a timeout by itself and records whether the hot-plug line signalled a disconnect. All outcome registers hold their value until the next capture or window expiry. The host reads the buffered bytes through an indexed port that can rewind to the first byte and step forward on each read.

Top module: `aux_reply_decoder`

## Requirements
- R1: After reset, `result` is 0 (none), `reply_code` is 6 (none), `data_count` is 0, `res_valid` and `disc_seen` are 0, and `rd_idx` is 0.
- R2: On `cap_done` with a nonzero `cap_count`, `reply_code` is decoded from bits 7:4 of buffer byte 0. Byte 0 must have been written in an earlier cycle. The mapping is: 0 gives 0 (channel ACK), 1 gives 1 (channel NACK), 2 gives 2 (channel DEFER), 4 gives 3 (I2C NACK), and 8 gives 4 (I2C DEFER). Any other nibble gives 5 (invalid). When `cap_count` is 0, the code is 6 (none).
- R3: With no error flag set and `cap_count` nonzero, `result` is 1 (success) and `data_count` is `cap_count` minus 1. For any other result, `data_count` is 0.
- R4: If either timeout flag (`rx_tmo_live`, `rx_tmo_seen`) is set at `cap_done`, `result` is 2 (timeout), whatever the other flags are.
- R5: With no timeout flag set, any of `rx_bad_stop`, `rx_no_detect`, `rx_bad_high` or `rx_bad_low` gives `result` 3 (invalid reply).
- R6: With no flags set, a completed capture with `cap_count` 0 gives `result` 3.
- R7: `rx_min_viol` has no effect on `result`, `reply_code` or `data_count`.
- R8: When `wait_start` is seen at a clock edge and no `cap_done` arrives in the following WAIT_LIMIT edges, the WAIT_LIMIT-th edge loads `result` 2, `reply_code` 6 and `data_count` 0. That same edge latches `hpd_lost` into `disc_seen`. A `cap_done` inside the window closes it, and no expiry follows. Every `cap_done` also latches `hpd_lost` into `disc_seen`.
- R9: `res_valid` is high for exactly the cycle after each `cap_done` or expiry edge. Outside those updates, `result`, `reply_code`, `data_count` and `disc_seen` hold.
- R10: `rd_data` is the buffer byte at `rd_idx`. `rd_rewind` sets `rd_idx` to 0. Otherwise, `rd_en` with `rd_autoinc` high advances `rd_idx` by one, wrapping from DEPTH-1 to 0. With `rd_autoinc` low, `rd_idx` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_we | input | 1 | Buffer write strobe from the receiver |
| cap_widx | input | IW | Buffer write index |
| cap_wdata | input | 8 | Buffer write byte |
| cap_done | input | 1 | Capture-complete strobe |
| cap_count | input | CW | Number of bytes received |
| rx_tmo_live | input | 1 | Receiver currently in timeout |
| rx_tmo_seen | input | 1 | Receiver timed out during this reply |
| rx_bad_stop | input | 1 | Malformed stop pattern |
| rx_no_detect | input | 1 | No valid reply detected |
| rx_bad_high | input | 1 | Invalid high half-bit |
| rx_bad_low | input | 1 | Invalid low half-bit |
| rx_min_viol | input | 1 | Debug-only minimum-count flag |
| hpd_lost | input | 1 | Hot-plug disconnect indication |
| wait_start | input | 1 | Arms the reply wait window |
| rd_rewind | input | 1 | Sets the read index to 0 |
| rd_en | input | 1 | Read strobe |
| rd_autoinc | input | 1 | Enables index advance on read |
| rd_data | output | 8 | Byte at the read index |
| rd_idx | output | IW | Current read index |
| res_valid | output | 1 | Outcome updated last edge |
| result | output | 2 | 0 none, 1 success, 2 timeout, 3 invalid |
| reply_code | output | 3 | Decoded reply code |
| data_count | output | CW | Payload bytes on success |
| disc_seen | output | 1 | Latched hot-plug disconnect |

## Verification
Two situations are the hardest to reach. The first is a wait-window expiry, which needs a long stretch with no capture. The second is a capture that lands inside the window and must prevent any later expiry. The stimulus arms the window and idles for exactly WAIT_LIMIT-1 edges, then one more. It then re-arms, completes a capture partway through, and counts the `res_valid` pulses over a span longer than the window. The decode itself is swept over every reply nibble, byte counts 0 to 4 and all 128 flag combinations, including the debug-only flag.

// File: rtl/aux_reply_decoder.sv
module aux_reply_decoder #(
  parameter int DEPTH      = 16,
  parameter int WAIT_LIMIT = 40,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(WAIT_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_we,
  input  logic [IW-1:0] cap_widx,
  input  logic [7:0]    cap_wdata,
  input  logic          cap_done,
  input  logic [CW-1:0] cap_count,
  input  logic          rx_tmo_live,
  input  logic          rx_tmo_seen,
  input  logic          rx_bad_stop,
  input  logic          rx_no_detect,
  input  logic          rx_bad_high,
  input  logic          rx_bad_low,
  input  logic          rx_min_viol,
  input  logic          hpd_lost,
  input  logic          wait_start,
  input  logic          rd_rewind,
  input  logic          rd_en,
  input  logic          rd_autoinc,
  output logic [7:0]    rd_data,
  output logic [IW-1:0] rd_idx,
  output logic          res_valid,
  output logic [1:0]    result,
  output logic [2:0]    reply_code,
  output logic [CW-1:0] data_count,
  output logic          disc_seen
);
  localparam logic [1:0] RES_NONE = 2'd0, RES_OK = 2'd1, RES_TMO = 2'd2, RES_BAD = 2'd3;
  localparam logic [2:0] C_ACK = 3'd0, C_NACK = 3'd1, C_DEFER = 3'd2, C_I2C_NACK = 3'd3,
                         C_I2C_DEFER = 3'd4, C_INVALID = 3'd5, C_NONE = 3'd6;

  logic [7:0] mem [DEPTH];
  logic [TW-1:0] wcnt;
  logic armed;
  logic [2:0] code_d;
  logic [1:0] res_d;

  always_ff @(posedge clk)
    if (cap_we) mem[cap_widx] <= cap_wdata;

  assign rd_data = mem[rd_idx];

  wire tmo_any = rx_tmo_live | rx_tmo_seen;
  wire bad_any = rx_bad_stop | rx_no_detect | rx_bad_high | rx_bad_low;
  wire empty   = (cap_count == '0);
  wire expire  = armed && !cap_done && (wcnt == TW'(WAIT_LIMIT - 1));

  always_comb begin
    case (mem[0][7:4])
      4'h0:    code_d = C_ACK;
      4'h1:    code_d = C_NACK;
      4'h2:    code_d = C_DEFER;
      4'h4:    code_d = C_I2C_NACK;
      4'h8:    code_d = C_I2C_DEFER;
      default: code_d = C_INVALID;
    endcase
    if (empty) code_d = C_NONE;
  end

  assign res_d = tmo_any ? RES_TMO : (bad_any || empty) ? RES_BAD : RES_OK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      wcnt       <= '0;
      res_valid  <= 1'b0;
      result     <= RES_NONE;
      reply_code <= C_NONE;
      data_count <= '0;
      disc_seen  <= 1'b0;
    end else begin
      res_valid <= cap_done | expire;
      armed     <= wait_start ? 1'b1 : (cap_done | expire) ? 1'b0 : armed;
      wcnt      <= wait_start ? '0 : armed ? wcnt + 1'b1 : wcnt;
      if (cap_done) begin
        result     <= res_d;
        reply_code <= code_d;
        data_count <= (res_d == RES_OK) ? cap_count - 1'b1 : '0;
        disc_seen  <= hpd_lost;
      end else if (expire) begin
        result     <= RES_TMO;
        reply_code <= C_NONE;
        data_count <= '0;
        disc_seen  <= hpd_lost;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   rd_idx <= '0;
    else if (rd_rewind)           rd_idx <= '0;
    else if (rd_en && rd_autoinc) rd_idx <= (rd_idx == IW'(DEPTH - 1)) ? '0 : rd_idx + 1'b1;
  end

  wire unused_ok = rx_min_viol;
endmodule

// File: rtl/aux_reply_decoder_chk.sv
module aux_reply_decoder_chk #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_done,
  input logic [CW-1:0] cap_count,
  input logic          rx_tmo_live,
  input logic          rx_tmo_seen,
  input logic          rd_rewind,
  input logic          rd_en,
  input logic          rd_autoinc,
  input logic [IW-1:0] rd_idx,
  input logic          res_valid,
  input logic [1:0]    result,
  input logic [2:0]    reply_code,
  input logic [CW-1:0] data_count
);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(result) && $stable(reply_code) && $stable(data_count));
  p_done_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> res_valid);
  p_tmo_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done && (rx_tmo_live || rx_tmo_seen) |=> result == 2'd2 && data_count == '0);
  p_count_only_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    result != 2'd1 |-> data_count == '0);
  p_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done && cap_count == '0 |=> result != 2'd1 && reply_code == 3'd6);
  p_rewind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rewind |=> rd_idx == '0);
  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && rd_autoinc && !rd_rewind && rd_idx != IW'(DEPTH - 1) |=> rd_idx == IW'($past(rd_idx) + 1'b1));
  p_idx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_rewind && !(rd_en && rd_autoinc) |=> $stable(rd_idx));
endmodule

bind aux_reply_decoder aux_reply_decoder_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/aux_reply_decoder_test.sv
`timescale 1ns/1ps
module aux_reply_decoder_test;
  localparam int DEPTH = 16, WAIT_LIMIT = 40;
  localparam int IW = $clog2(DEPTH), CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic cap_we = 0, cap_done = 0, wait_start = 0, rd_rewind = 0, rd_en = 0, rd_autoinc = 0;
  logic [IW-1:0] cap_widx = '0;
  logic [7:0] cap_wdata = '0;
  logic [CW-1:0] cap_count = '0;
  logic [6:0] fl = '0;
  logic hpd_lost = 0;
  logic [7:0] rd_data;
  logic [IW-1:0] rd_idx;
  logic res_valid, disc_seen;
  logic [1:0] result;
  logic [2:0] reply_code;
  logic [CW-1:0] data_count;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  aux_reply_decoder #(.DEPTH(DEPTH), .WAIT_LIMIT(WAIT_LIMIT)) uut (
    .clk, .rst_n, .cap_we, .cap_widx, .cap_wdata, .cap_done, .cap_count,
    .rx_tmo_live(fl[0]), .rx_tmo_seen(fl[1]), .rx_bad_stop(fl[2]), .rx_no_detect(fl[3]),
    .rx_bad_high(fl[4]), .rx_bad_low(fl[5]), .rx_min_viol(fl[6]), .hpd_lost,
    .wait_start, .rd_rewind, .rd_en, .rd_autoinc, .rd_data, .rd_idx,
    .res_valid, .result, .reply_code, .data_count, .disc_seen);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int nib, input int cnt);
    if (cnt == 0) return 6;
    case (nib)
      0: return 0; 1: return 1; 2: return 2; 4: return 3; 8: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int exp_res(input int cnt, input logic [6:0] f);
    if (f[0] | f[1]) return 2;
    if (|f[5:2]) return 3;
    if (cnt == 0) return 3;
    return 1;
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 8'hff);
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int pulses;
    repeat (3) @(negedge clk);
    chk(result == 2'd0, "R1 result", result, 0);
    chk(reply_code == 3'd6, "R1 code", reply_code, 6);
    chk(data_count == '0 && !res_valid && !disc_seen, "R1 count/valid/disc", data_count, 0);
    chk(rd_idx == '0, "R1 rd_idx", rd_idx, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 sweep: every nibble, counts 0..4, all flag sets
    for (int nib = 0; nib < 16; nib++)
      for (int cnt = 0; cnt < 5; cnt++)
        for (int f = 0; f < 128; f++) begin
          int er, ec, en;
          cap_we = 1; cap_widx = '0; cap_wdata = {4'(nib), 4'(f ^ cnt)};
          @(negedge clk);
          cap_we = 0; cap_done = 1; cap_count = CW'(cnt); fl = 7'(f);
          hpd_lost = f[0] ^ nib[0];
          @(negedge clk);
          cap_done = 0; fl = '0;
          er = exp_res(cnt, 7'(f));
          ec = exp_code(nib, cnt);
          en = (er == 1) ? cnt - 1 : 0;
          if (!(result == 2'(er)))
            chk(0, (f[6] ? "R7 R4 R5 R6 result" : "R4 R5 R6 result"), result, er);
          else chk(1, "R4", 0, 0);
          if (!(reply_code == 3'(ec))) chk(0, "R2 code", reply_code, ec);
          else chk(1, "R2", 0, 0);
          if (!(data_count == CW'(en))) chk(0, "R3 data_count", data_count, en);
          else chk(1, "R3", 0, 0);
          if (!(res_valid && disc_seen == hpd_lost)) chk(0, "R9 R8 valid/disc", {res_valid, disc_seen}, {1'b1, hpd_lost});
          else chk(1, "R9", 0, 0);
        end

    // R9 hold: flags and count toggle without a capture strobe
    cap_we = 1; cap_wdata = 8'h10; @(negedge clk); cap_we = 0;
    cap_done = 1; cap_count = CW'(3); @(negedge clk); cap_done = 0;
    for (int k = 0; k < 6; k++) begin
      fl = 7'(k * 21); cap_count = CW'(k); hpd_lost = k[0];
      @(negedge clk);
      chk(!res_valid, "R9 no pulse", res_valid, 0);
      chk(result == 2'd1 && reply_code == 3'd1 && data_count == CW'(2) && !disc_seen,
          "R9 hold", {result, reply_code}, {2'd1, 3'd1});
    end
    fl = '0;

    // R8 expiry: nothing for WAIT_LIMIT-1 edges, then timeout
    hpd_lost = 1; wait_start = 1; @(negedge clk); wait_start = 0;
    repeat (WAIT_LIMIT - 1) @(negedge clk);
    chk(!res_valid && result == 2'd1, "R8 not yet", result, 1);
    @(negedge clk);
    chk(res_valid && result == 2'd2, "R8 expired", result, 2);
    chk(reply_code == 3'd6 && data_count == '0 && disc_seen, "R8 code/disc", reply_code, 6);
    @(negedge clk);
    chk(!res_valid, "R9 single pulse", res_valid, 0);

    // R8 capture inside the window closes it
    hpd_lost = 0; wait_start = 1; @(negedge clk); wait_start = 0;
    repeat (5) @(negedge clk);
    cap_done = 1; cap_count = CW'(4); @(negedge clk); cap_done = 0;
    pulses = 0;
    for (int k = 0; k < 3 * WAIT_LIMIT; k++) begin
      if (res_valid) pulses++;
      @(negedge clk);
    end
    chk(pulses == 1, "R8 no late expiry", pulses, 1);
    chk(result == 2'd1 && data_count == CW'(3) && !disc_seen, "R8 capture result", result, 1);

    // R10 indexed read port
    for (int i = 0; i < DEPTH; i++) begin
      cap_we = 1; cap_widx = IW'(i); cap_wdata = pat(i); @(negedge clk);
    end
    cap_we = 0;
    rd_en = 1; rd_autoinc = 1; @(negedge clk); @(negedge clk);
    rd_en = 0; rd_rewind = 1; @(negedge clk); rd_rewind = 0;
    chk(rd_idx == '0, "R10 rewind", rd_idx, 0);
    rd_en = 1; rd_autoinc = 1;
    for (int k = 0; k < DEPTH + 3; k++) begin
      chk(rd_idx == IW'(k % DEPTH) && rd_data == pat(k % DEPTH), "R10 autoinc",
          rd_data, pat(k % DEPTH));
      @(negedge clk);
    end
    rd_autoinc = 0;
    begin
      logic [IW-1:0] held;
      held = rd_idx;
      repeat (4) @(negedge clk);
      chk(rd_idx == held && rd_data == pat(held), "R10 no advance", rd_idx, held);
    end
    rd_en = 0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule